// File: doc/BRIEF.md
# Nonvolatile Byte Store Write Interlock

This block guards a 512-byte nonvolatile data array, held here as an internal register array, behind a small register interface. Software loads an address register and a data register. It then writes a control register whose three bits are arm, go and read. A write into the array can only begin through a two-step sequence. First a control write sets arm with go clear, which opens a short window. Then a control write with go set must arrive before that window closes. A stray or late go does nothing.

Once started, a write keeps its busy flag high for a parameterized number of cycles. During that time the address and data registers are frozen and read requests are dropped. At the end the byte is committed, busy drops and a one-cycle done flag pulses. A write cannot start while an external program-memory write is in progress. A read copies the addressed byte into the data register on the next clock edge.

Top module: `nvm_write_interlock`

## Requirements
- R1: After reset, armed_o, wr_busy_o and done_o are 0 and data_o is 0. The address register has no defined reset value.
- R2: A control write (reg_sel_i=2) with bit 2 (arm) set and bit 1 (go) clear raises armed_o at the next edge. Unless a write starts, armed_o stays high for exactly 4 cycles and then clears itself.
- R3: A control write with go set while armed_o is 0 has no effect: wr_busy_o stays 0 and the array is unchanged. This includes a single control write carrying both arm and go.
- R4: A control write with go set while armed_o is 1 starts a write. wr_busy_o is high from the next edge for exactly WR_LAT cycles, and armed_o clears.
- R5: At the end of a write, the data register byte is stored at the address register location, wr_busy_o falls, and done_o is high for exactly one cycle.
- R6: While prog_busy_i is 1, a go request does not start a write.
- R7: A control write with bit 0 (read) set loads data_o with the byte at the address register location at the next edge.
- R8: A read request issued while wr_busy_o is 1 is ignored, and data_o keeps its value.
- R9: Writes to the address register (reg_sel_i=0) and the data register (reg_sel_i=1) are ignored while wr_busy_o is 1.
- R10: The address selects bytes linearly from 0 to DEPTH-1. Locations 0 and 511 are distinct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write request for this cycle |
| reg_sel_i | input | 2 | Register select: 0 address, 1 data, 2 control |
| reg_wdata_i | input | 16 | Write value; control bits are 0 read, 1 go, 2 arm |
| prog_busy_i | input | 1 | Program-memory write in progress |
| addr_o | output | ADDR_W | Address register |
| data_o | output | DATA_W | Data register |
| armed_o | output | 1 | Arm window open |
| wr_busy_o | output | 1 | Array write in progress |
| done_o | output | 1 | One-cycle pulse when a write completes |

## Verification
If the arm window counter is off, the accepted go position moves by a cycle. The bench probes the fourth and fifth cycles after arming, so the error shows within one write attempt. If the latency counter is off, wr_busy_o has the wrong length, and the bench counts that on every write. If the freeze during a busy write is broken, data_o or addr_o change mid-write, and the next readback returns the wrong byte. A commit error appears at the ports only when the location is read back, so every table entry is read after all the writes are done.

// File: rtl/nvm_ilk_pkg.sv
package nvm_ilk_pkg;
  localparam int unsigned BUS_W = 16;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic arm;
    logic go;
    logic rd;
  } ctrl_t;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
  parameter int unsigned WIN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_req_i,
  input  logic consume_i,
  output logic armed_o
);
  localparam int unsigned CW = (WIN > 1) ? $clog2(WIN) : 1;

  logic          armed_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (consume_i) begin
      armed_q <= 1'b0;
    end else if (arm_req_i) begin
      armed_q <= 1'b1;
      cnt_q   <= CW'(WIN - 1);
    end else if (armed_q) begin
      if (cnt_q == '0) armed_q <= 1'b0;
      else             cnt_q   <= cnt_q - CW'(1);
    end
  end

  assign armed_o = armed_q;

  // independent age tracker for the window bound
  logic [CW:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        age_q <= '0;
    else if (arm_req_i) age_q <= '0;
    else if (armed_q)   age_q <= age_q + (CW+1)'(1);
  end

  AST_ARM_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (age_q < (CW+1)'(WIN))); // R2
endmodule

// File: rtl/nvm_write_seq.sv
module nvm_write_seq #(
  parameter int unsigned LAT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic commit_o,
  output logic done_o
);
  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(LAT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign commit_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= commit_o;
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // run-length tracker
  logic [CW:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_q) run_q <= run_q + (CW+1)'(1);
    else             run_q <= '0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (run_q < (CW+1)'(LAT))); // R4
  AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(busy_q) && !busy_q)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R5
endmodule

// File: rtl/nvm_byte_array.sv
module nvm_byte_array #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nvm_write_interlock.sv
module nvm_write_interlock #(
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned WR_LAT  = 8,
  parameter int unsigned ARM_WIN = 4,
  parameter int unsigned ADDR_W  = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           reg_wr_i,
  input  logic [1:0]                     reg_sel_i,
  input  logic [nvm_ilk_pkg::BUS_W-1:0]  reg_wdata_i,
  input  logic                           prog_busy_i,
  output logic [ADDR_W-1:0]              addr_o,
  output logic [DATA_W-1:0]              data_o,
  output logic                           armed_o,
  output logic                           wr_busy_o,
  output logic                           done_o
);
  import nvm_ilk_pkg::*;

  reg_sel_e          sel;
  ctrl_t             ctrl;
  logic              ctrl_wr, arm_req, start, rd_ok, commit;
  logic              armed, busy;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q, rdata;

  assign sel     = reg_sel_e'(reg_sel_i);
  assign ctrl    = ctrl_t'(reg_wdata_i[2:0]);
  assign ctrl_wr = reg_wr_i && (sel == SEL_CTRL);
  assign arm_req = ctrl_wr && ctrl.arm && !ctrl.go;
  assign start   = ctrl_wr && ctrl.go && armed && !busy && !prog_busy_i;
  // read is dropped if busy or if the same write starts a store
  assign rd_ok   = ctrl_wr && ctrl.rd && !busy && !start;

  nvm_arm_window #(.WIN(ARM_WIN)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_req_i (arm_req),
    .consume_i (start),
    .armed_o   (armed)
  );

  nvm_write_seq #(.LAT(WR_LAT)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .busy_o   (busy),
    .commit_o (commit),
    .done_o   (done_o)
  );

  nvm_byte_array #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (commit),
    .addr_i  (addr_q),
    .wdata_i (data_q),
    .rdata_o (rdata)
  );

  // address has no reset value by definition
  always_ff @(posedge clk_i) begin
    if (reg_wr_i && sel == SEL_ADDR && !busy) addr_q <= reg_wdata_i[ADDR_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
    end else if (!busy) begin
      if (reg_wr_i && sel == SEL_DATA) data_q <= reg_wdata_i[DATA_W-1:0];
      else if (rd_ok)                  data_q <= rdata;
    end
  end

  assign addr_o    = addr_q;
  assign data_o    = data_q;
  assign armed_o   = armed;
  assign wr_busy_o = busy;

  AST_START_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_o) |-> $past(armed_o)); // R4
  AST_NO_START_PROG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_o) |-> !$past(prog_busy_i)); // R6
  AST_REGS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_busy_o) |-> ($stable(addr_q) && $stable(data_q))); // R9
  AST_ARM_CLEARS_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_busy_o) |-> !armed_o); // R4
endmodule

// File: tb/tb_nvm_write_interlock.sv
module tb_nvm_write_interlock;
  localparam int CLK_P  = 10;
  localparam int WR_LAT = 8;
  localparam logic [15:0] C_ARM = 16'h4;
  localparam logic [15:0] C_GO  = 16'h2;
  localparam logic [15:0] C_RD  = 16'h1;
  localparam int NVEC = 8;
  // {address, byte}
  localparam logic [16:0] VEC [NVEC] = '{
    {9'd0,   8'h5A}, {9'd511, 8'hA5}, {9'd1,   8'h01}, {9'd256, 8'hFF},
    {9'd255, 8'h6B}, {9'd128, 8'h3C}, {9'd2,   8'hC3}, {9'd510, 8'h7E}
  };

  logic        clk = 0;
  logic        rst_ni = 0;
  logic        reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic        prog_busy = 0;
  logic [8:0]  addr_o;
  logic [7:0]  data_o;
  logic        armed_o, wr_busy_o, done_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  nvm_write_interlock #(.WR_LAT(WR_LAT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .prog_busy_i(prog_busy), .addr_o(addr_o),
    .data_o(data_o), .armed_o(armed_o), .wr_busy_o(wr_busy_o), .done_o(done_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_wr = 1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic full_write(input logic [8:0] a, input logic [7:0] d);
    int n;
    bus(2'd0, {7'd0, a});
    bus(2'd1, {8'd0, d});
    bus(2'd2, C_ARM);
    bus(2'd2, C_GO);
    n = 0;
    while (wr_busy_o && n < 100) begin n++; @(negedge clk); end
    chk("R4 busy length", n, WR_LAT);
    chk("R5 done pulse", done_o, 1);
    @(negedge clk);
    chk("R5 done single", done_o, 0);
  endtask

  task automatic read_at(input logic [8:0] a, output logic [7:0] d);
    bus(2'd0, {7'd0, a});
    bus(2'd2, C_RD);
    d = data_o;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    idle(3);
    chk("R1 armed", armed_o, 0);
    chk("R1 busy", wr_busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 data", data_o, 0);
    rst_ni = 1;
    idle(2);

    // table walk: write all, then read back all (R5, R7, R10)
    for (int i = 0; i < NVEC; i++) full_write(VEC[i][16:8], VEC[i][7:0]);
    for (int i = 0; i < NVEC; i++) begin
      read_at(VEC[i][16:8], rd);
      chk("R7 R10 readback", rd, VEC[i][7:0]);
    end

    // R3: go without arm
    full_write(9'd20, 8'h11);
    bus(2'd1, 16'h0099);
    bus(2'd2, C_GO);
    chk("R3 no start", wr_busy_o, 0);
    bus(2'd2, C_ARM | C_GO);
    chk("R3 arm+go no start", wr_busy_o, 0);
    chk("R3 arm+go no arm", armed_o, 0);
    idle(WR_LAT + 2);
    read_at(9'd20, rd);
    chk("R3 array unchanged", rd, 8'h11);

    // R2: window expiry
    bus(2'd2, C_ARM);
    chk("R2 armed set", armed_o, 1);
    idle(3);
    chk("R2 armed cycle 4", armed_o, 1);
    idle(1);
    chk("R2 armed cleared", armed_o, 0);
    bus(2'd0, 16'd21);
    bus(2'd1, 16'h0077);
    bus(2'd2, C_GO);
    chk("R3 late go ignored", wr_busy_o, 0);

    // R4: go on last window cycle
    bus(2'd2, C_ARM);
    idle(2);
    bus(2'd2, C_GO);
    chk("R4 last-cycle go starts", wr_busy_o, 1);
    chk("R4 armed cleared", armed_o, 0);
    idle(WR_LAT + 1);
    read_at(9'd21, rd);
    chk("R5 stored", rd, 8'h77);

    // R6: program-memory busy
    bus(2'd1, 16'h0033);
    prog_busy = 1;
    bus(2'd2, C_ARM);
    bus(2'd2, C_GO);
    chk("R6 blocked", wr_busy_o, 0);
    prog_busy = 0;
    idle(WR_LAT + 2);
    read_at(9'd21, rd);
    chk("R6 unchanged", rd, 8'h77);

    // R8, R9: accesses during busy
    bus(2'd0, 16'd40);
    bus(2'd1, 16'h0044);
    bus(2'd2, C_ARM);
    bus(2'd2, C_GO);
    bus(2'd0, 16'd41);
    bus(2'd1, 16'h0055);
    chk("R9 addr frozen", addr_o, 40);
    chk("R9 data frozen", data_o, 8'h44);
    bus(2'd2, C_RD);
    chk("R8 read ignored", data_o, 8'h44);
    while (wr_busy_o) @(negedge clk);
    idle(1);
    read_at(9'd40, rd);
    chk("R9 committed byte", rd, 8'h44);
    read_at(9'd41, rd);
    chk("R9 no stray write", rd, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule